// File: doc/BRIEF.md
# PSK Hard-Decision Slicer

This block turns one complex baseband sample per accepted cycle into a hard symbol decision for a binary, four-point or eight-point phase constellation. The order is fixed by a parameter. The decision needs no angle computation. It compares the signs of the in-phase and quadrature parts and, for eight points, their magnitudes. The constellation is assumed to sit at the angle where every decision boundary falls on an axis or a diagonal. For eight points the first point is at 22.5 degrees, for four points at 45 degrees, and for two points at 0 degrees. Positions are counted counterclockwise from that first point.

The position index is then relabelled by a Gray code, by natural binary, or by a permutation table supplied as a parameter. The result leaves the block in one of two forms. In word mode it is a symbol-wide integer. In bit mode it is a serial stream, one bit per cycle, most significant bit first. Separate parameters set the number of register stages in front of the slicer and behind the labeller. Samples enter through a valid/ready pair. Ready only drops in bit mode, to pace the input to the serialiser.

Top module: `psk_slicer`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With ORDER=8, position k covers angles from k·45° up to, but not including, (k+1)·45°, measured counterclockwise from the positive I axis. A zero component counts as non-negative. A sample with |I|=|Q| goes to the sector next to the I axis, which is position 0, 3, 4 or 7.
- R3: With ORDER=4, the position is 0 for I≥0,Q≥0; 1 for I<0,Q≥0; 2 for I<0,Q<0; and 3 for I≥0,Q<0.
- R4: With ORDER=2, the position is 1 exactly when I is negative, and the value of Q has no effect.
- R5: With MAPPING=MAP_GRAY, the label is pos XOR (pos >> 1).
- R6: With MAPPING=MAP_BINARY, the label equals the position.
- R7: With MAPPING=MAP_TABLE, the label for position k is held in bits [4k +: log2(ORDER)] of TABLE. Each entry occupies a 4-bit slot.
- R8: In word mode (BIT_MODE=0), `in_ready` stays high. Each accepted sample yields exactly one label, in order, IN_STAGES+OUT_STAGES cycles after the accepting edge. When the sum is 0, the path is combinational.
- R9: In bit mode, each symbol yields log2(ORDER) bits on `out_data[0]` with `out_valid` high, most significant bit first, on consecutive cycles. The first bit appears IN_STAGES+OUT_STAGES+1 cycles after the accepting edge.
- R10: In bit mode, `in_ready` is low for log2(ORDER)-1 cycles after each accepted sample. A sample offered while it is low is not taken and produces no output.
- R11: In bit mode, when samples are offered continuously, the bit stream has no gap between symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample is taken on this edge if valid |
| in_i | input | IW | In-phase part, two's complement |
| in_q | input | IW | Quadrature part, two's complement |
| out_valid | output | 1 | Label word or label bit is present |
| out_data | output | BIT_MODE ? 1 : log2(ORDER) | Label (word mode) or current label bit (bit mode) |

## Verification
The bench drives samples exactly on the boundaries: zero components, |I|=|Q| in all four quadrants, and the most negative code. A slicer with a wrong tie rule or a wrong magnitude compare would put these into the neighbouring sector, and a magnitude that overflows would turn -2048 into a small value. For the bit-serial configuration, the bench offers a sample while ready is low and sends symbols back to back. A design that took the offered sample would emit an extra symbol. A design that paced the input badly would leave gaps in the stream or overwrite the previous symbol's bits. Every label is also checked against the cycle in which it should appear, so an added or missing pipeline stage is caught in each configuration.

// File: rtl/psk_slicer_pkg.sv
package psk_slicer_pkg;

    // Label assignment applied to the position index
    typedef enum logic [1:0] {
        MAP_GRAY   = 2'd0,
        MAP_BINARY = 2'd1,
        MAP_TABLE  = 2'd2
    } map_kind_e;

    // Sign and dominance flags of one sample
    typedef struct packed {
        logic i_neg;
        logic q_neg;
        logic i_dom;
    } sector_t;

    // Width of one entry slot in the permutation table parameter
    localparam int unsigned TABLE_SLOT = 4;

    function automatic logic [3:0] gray_of(input logic [3:0] x);
        return x ^ (x >> 1);
    endfunction

    // Quadrant counted counterclockwise from the first quadrant
    function automatic logic [1:0] quadrant_of(input sector_t s);
        return {s.q_neg, s.i_neg ^ s.q_neg};
    endfunction

endpackage

// File: rtl/psk_pipe.sv
module psk_pipe #(
    parameter int W      = 8,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    generate
        if (STAGES == 0) begin : g_wire
            assign out_v = in_v;
            assign out_d = in_d;
        end else begin : g_regs
            logic [STAGES-1:0] v_q;
            logic [W-1:0]      d_q [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= '0;
                end else begin
                    v_q[0] <= in_v;
                    for (int k = 1; k < STAGES; k++) begin
                        v_q[k] <= v_q[k-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                d_q[0] <= in_d;
                for (int k = 1; k < STAGES; k++) begin
                    d_q[k] <= d_q[k-1];
                end
            end

            assign out_v = v_q[STAGES-1];
            assign out_d = d_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/psk_sector.sv
module psk_sector
    import psk_slicer_pkg::*;
#(
    parameter int IW    = 12,
    parameter int ORDER = 8
) (
    input  logic signed [IW-1:0]           smp_i,
    input  logic signed [IW-1:0]           smp_q,
    output logic [$clog2(ORDER)-1:0]       pos
);

    sector_t flags;

    assign flags.i_neg = smp_i[IW-1];
    assign flags.q_neg = smp_q[IW-1];

    generate
        if (ORDER == 8) begin : g_eight
            // One extra bit so that the most negative code has a magnitude
            logic [IW:0] ext_i, ext_q, mag_i, mag_q;
            logic [1:0]  quad;

            assign ext_i = {smp_i[IW-1], smp_i};
            assign ext_q = {smp_q[IW-1], smp_q};
            assign mag_i = flags.i_neg ? (~ext_i + 1'b1) : ext_i;
            assign mag_q = flags.q_neg ? (~ext_q + 1'b1) : ext_q;
            // Ties go to the sector bordering the I axis
            assign flags.i_dom = (mag_i >= mag_q);
            assign quad = quadrant_of(flags);
            // Even quadrants start I-dominant, odd quadrants start Q-dominant
            assign pos = {quad, quad[0] ? flags.i_dom : ~flags.i_dom};
        end else if (ORDER == 4) begin : g_four
            assign flags.i_dom = 1'b0;
            assign pos = quadrant_of(flags);
        end else begin : g_two
            assign flags.i_dom = 1'b0;
            assign pos = flags.i_neg;
        end
    endgenerate

endmodule

// File: rtl/psk_labeler.sv
module psk_labeler
    import psk_slicer_pkg::*;
#(
    parameter int        ORDER   = 8,
    parameter map_kind_e MAPPING = MAP_GRAY,
    parameter logic [31:0] TABLE = 32'h7654_3210
) (
    input  logic [$clog2(ORDER)-1:0] pos,
    output logic [$clog2(ORDER)-1:0] label
);

    localparam int SW = $clog2(ORDER);

    generate
        if (MAPPING == MAP_GRAY) begin : g_gray
            assign label = SW'(gray_of(4'(pos)));
        end else if (MAPPING == MAP_TABLE) begin : g_table
            logic [TABLE_SLOT-1:0] slot;
            assign slot  = TABLE[TABLE_SLOT*pos +: TABLE_SLOT];
            assign label = slot[SW-1:0];
        end else begin : g_binary
            assign label = pos;
        end
    endgenerate

endmodule

// File: rtl/psk_serializer.sv
module psk_serializer #(
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] sym,
    output logic          bit_v,
    output logic          bit_o
);

    localparam int CW = $clog2(SW + 1);

    logic [CW-1:0] left_q;
    logic [SW-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(SW);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            shreg_q <= sym;
        end else begin
            shreg_q <= shreg_q << 1;
        end
    end

    assign bit_v = (left_q != '0);
    assign bit_o = shreg_q[SW-1];

endmodule

// File: rtl/psk_slicer.sv
module psk_slicer
    import psk_slicer_pkg::*;
#(
    parameter int          ORDER      = 8,
    parameter int          IW         = 12,
    parameter map_kind_e   MAPPING    = MAP_GRAY,
    parameter logic [31:0] TABLE      = 32'h7654_3210,
    parameter bit          BIT_MODE   = 1'b0,
    parameter int          IN_STAGES  = 1,
    parameter int          OUT_STAGES = 1
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        in_valid,
    output logic                                        in_ready,
    input  logic signed [IW-1:0]                        in_i,
    input  logic signed [IW-1:0]                        in_q,
    output logic                                        out_valid,
    output logic [(BIT_MODE ? 1 : $clog2(ORDER))-1:0]  out_data
);

    localparam int SW = $clog2(ORDER);

    logic                 take;
    logic                 sl_v;
    logic [2*IW-1:0]      sl_d;
    logic signed [IW-1:0] sl_i, sl_q;
    logic [SW-1:0]        sl_pos, sl_lbl;
    logic                 sym_v;
    logic [SW-1:0]        sym;

    assign take = in_valid && in_ready;

    psk_pipe #(.W(2*IW), .STAGES(IN_STAGES)) i_front (
        .clk(clk), .rst(rst),
        .in_v(take), .in_d({in_i, in_q}),
        .out_v(sl_v), .out_d(sl_d)
    );

    assign sl_i = sl_d[2*IW-1:IW];
    assign sl_q = sl_d[IW-1:0];

    psk_sector #(.IW(IW), .ORDER(ORDER)) i_sector (
        .smp_i(sl_i), .smp_q(sl_q), .pos(sl_pos)
    );

    psk_labeler #(.ORDER(ORDER), .MAPPING(MAPPING), .TABLE(TABLE)) i_label (
        .pos(sl_pos), .label(sl_lbl)
    );

    psk_pipe #(.W(SW), .STAGES(OUT_STAGES)) i_back (
        .clk(clk), .rst(rst),
        .in_v(sl_v), .in_d(sl_lbl),
        .out_v(sym_v), .out_d(sym)
    );

    generate
        if (BIT_MODE) begin : g_bits
            logic bit_o;

            psk_serializer #(.SW(SW)) i_ser (
                .clk(clk), .rst(rst),
                .load(sym_v), .sym(sym),
                .bit_v(out_valid), .bit_o(bit_o)
            );
            assign out_data = bit_o;

            if (SW > 1) begin : g_pace
                localparam int HW = $clog2(SW);
                logic [HW-1:0] hold_q;
                // Spacing accepts SW cycles apart keeps the serialiser fed without overlap
                always_ff @(posedge clk) begin
                    if (rst) begin
                        hold_q <= '0;
                    end else if (take) begin
                        hold_q <= HW'(SW - 1);
                    end else if (hold_q != '0) begin
                        hold_q <= hold_q - 1'b1;
                    end
                end
                assign in_ready = (hold_q == '0);
            end else begin : g_free
                assign in_ready = 1'b1;
            end
        end else begin : g_word
            assign in_ready  = 1'b1;
            assign out_valid = sym_v;
            assign out_data  = sym;
        end
    endgenerate

endmodule

// File: rtl/psk_slicer_chk.sv
module psk_slicer_chk #(
    parameter int ORDER      = 8,
    parameter int IW         = 12,
    parameter bit BIT_MODE   = 1'b0,
    parameter int IN_STAGES  = 1,
    parameter int OUT_STAGES = 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       out_valid,
    input logic                       sl_v,
    input logic signed [IW-1:0]       sl_i,
    input logic signed [IW-1:0]       sl_q,
    input logic [$clog2(ORDER)-1:0]   sl_pos
);

    localparam int SW  = $clog2(ORDER);
    localparam int LAT = IN_STAGES + OUT_STAGES;

    logic acc;
    assign acc = in_valid && in_ready;

    generate
        if (!BIT_MODE) begin : g_word
            if (LAT == 0) begin : g_comb
                // R8
                word_latency_chk: assert property (@(posedge clk) disable iff (rst)
                    out_valid == acc);
            end else begin : g_seq
                logic [LAT-1:0] line_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        line_q <= '0;
                    end else begin
                        line_q[0] <= acc;
                        for (int k = 1; k < LAT; k++) begin
                            line_q[k] <= line_q[k-1];
                        end
                    end
                end
                // R8
                word_latency_chk: assert property (@(posedge clk) disable iff (rst)
                    out_valid == line_q[LAT-1]);
            end
        end else if (SW > 1) begin : g_bits
            // R10
            ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
                acc |=> !in_ready);
        end

        if (ORDER >= 4) begin : g_half
            // R3
            lower_half_chk: assert property (@(posedge clk) disable iff (rst)
                (sl_v && sl_q < 0) |-> (int'(sl_pos) >= ORDER / 2));
        end

        if (ORDER == 8) begin : g_first
            // R2
            first_sector_chk: assert property (@(posedge clk) disable iff (rst)
                (sl_v && sl_q > 0 && sl_i > sl_q) |-> (sl_pos == '0));
        end

        if (ORDER == 2) begin : g_bin
            // R4
            sign_only_chk: assert property (@(posedge clk) disable iff (rst)
                sl_v |-> (sl_pos[0] == (sl_i < 0)));
        end
    endgenerate

endmodule

bind psk_slicer psk_slicer_chk #(
    .ORDER(ORDER), .IW(IW), .BIT_MODE(BIT_MODE),
    .IN_STAGES(IN_STAGES), .OUT_STAGES(OUT_STAGES)
) i_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .sl_v(sl_v), .sl_i(sl_i), .sl_q(sl_q), .sl_pos(sl_pos)
);

// File: tb/test_psk_slicer.sv
module test_psk_slicer;
    import psk_slicer_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic              vv [4];
    logic signed [11:0] ii [4];
    logic signed [11:0] qq [4];
    logic ra, rb, rc, rd;
    logic ova, ovb, ovc, ovd;
    logic [2:0] oda;
    logic [0:0] odb;
    logic [2:0] odc;
    logic [0:0] odd;

    // 0: 8 points, Gray, word mode, 1+1 stages
    psk_slicer i_psk_slicer (
        .clk(clk), .rst(rst), .in_valid(vv[0]), .in_ready(ra),
        .in_i(ii[0]), .in_q(qq[0]), .out_valid(ova), .out_data(oda));

    // 1: 4 points, binary, bit mode, 1+2 stages
    psk_slicer #(.ORDER(4), .MAPPING(MAP_BINARY), .BIT_MODE(1'b1),
                 .IN_STAGES(1), .OUT_STAGES(2)) i_psk_slicer_qb (
        .clk(clk), .rst(rst), .in_valid(vv[1]), .in_ready(rb),
        .in_i(ii[1]), .in_q(qq[1]), .out_valid(ovb), .out_data(odb));

    // 2: 8 points, table, word mode, combinational
    psk_slicer #(.ORDER(8), .MAPPING(MAP_TABLE), .TABLE(32'h4163_0725),
                 .IN_STAGES(0), .OUT_STAGES(0)) i_psk_slicer_tab (
        .clk(clk), .rst(rst), .in_valid(vv[2]), .in_ready(rc),
        .in_i(ii[2]), .in_q(qq[2]), .out_valid(ovc), .out_data(odc));

    // 3: 2 points, Gray, bit mode, 2+0 stages
    psk_slicer #(.ORDER(2), .BIT_MODE(1'b1),
                 .IN_STAGES(2), .OUT_STAGES(0)) i_psk_slicer_bp (
        .clk(clk), .rst(rst), .in_valid(vv[3]), .in_ready(rd),
        .in_i(ii[3]), .in_q(qq[3]), .out_valid(ovd), .out_data(odd));

    typedef struct {
        int    d;
        int    val;
        int    cyc;
        string req;
    } exp_t;
    exp_t sb[$];

    int tbl [8] = '{5, 2, 7, 0, 3, 6, 1, 4};

    function automatic int order_of(int d);
        case (d)
            0: return 8;
            1: return 4;
            2: return 8;
            default: return 2;
        endcase
    endfunction

    function automatic int lat_of(int d);
        case (d)
            0: return 2;
            1: return 3;
            2: return 0;
            default: return 2;
        endcase
    endfunction

    function automatic bit bits_of(int d);
        return (d == 1) || (d == 3);
    endfunction

    function automatic logic ready_of(int d);
        case (d)
            0: return ra;
            1: return rb;
            2: return rc;
            default: return rd;
        endcase
    endfunction

    // Position from the sample angle (valid away from sector boundaries)
    function automatic int angle_pos(int m, int i, int q);
        real ang;
        ang = $atan2(real'(q), real'(i)) * 180.0 / 3.14159265358979;
        if (ang < 0.0) ang = ang + 360.0;
        if (m == 2) return (ang > 90.0 && ang < 270.0) ? 1 : 0;
        return $rtoi(ang / (360.0 / real'(m)));
    endfunction

    function automatic int label_of(int d, int pos);
        case (d)
            1: return pos;
            2: return tbl[pos];
            default: return pos ^ (pos >> 1);
        endcase
    endfunction

    task automatic fail_line(string req, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic observe(int d, logic v, int val);
        int idx;
        if (v !== 1'b1) return;
        idx = -1;
        for (int k = 0; k < sb.size(); k++) begin
            if (sb[k].d == d) begin idx = k; break; end
        end
        checks++;
        if (idx < 0) begin
            fail_line(bits_of(d) ? "R10" : "R8", $sformatf("dut%0d spurious output", d), val, -1);
            return;
        end
        if (sb[idx].val != val)
            fail_line(sb[idx].req, $sformatf("dut%0d label", d), val, sb[idx].val);
        else if (sb[idx].cyc != cyc)
            fail_line(bits_of(d) ? "R11" : "R8", $sformatf("dut%0d output cycle", d), cyc, sb[idx].cyc);
        sb.delete(idx);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            observe(0, ova, int'(oda));
            observe(1, ovb, int'(odb));
            observe(2, ovc, int'(odc));
            observe(3, ovd, int'(odd));
        end
    end

    // Offer one sample; pos < 0 means derive it from the angle
    task automatic push(int d, int i, int q, int pos, string req);
        int p, lbl, acc, sw;
        exp_t e;
        p = (pos < 0) ? angle_pos(order_of(d), i, q) : pos;
        lbl = label_of(d, p);
        vv[d] = 1'b1;
        ii[d] = 12'(i);
        qq[d] = 12'(q);
        while (ready_of(d) !== 1'b1) begin
            @(posedge clk); #2;
        end
        acc = cyc + 1;
        if (bits_of(d)) begin
            sw = $clog2(order_of(d));
            for (int j = 0; j < sw; j++) begin
                e.d = d; e.val = (lbl >> (sw - 1 - j)) & 1;
                e.cyc = acc + lat_of(d) + j; e.req = {req, " R9"};
                sb.push_back(e);
            end
        end else begin
            e.d = d; e.val = lbl; e.cyc = acc + lat_of(d) - 1; e.req = req;
            sb.push_back(e);
        end
        @(posedge clk); #2;
        vv[d] = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(posedge clk);
        #2;
    endtask

    task automatic push_random(int d, int n, string req);
        for (int k = 0; k < n; k++) begin
            int i, q, a, b;
            do begin
                i = int'($urandom_range(4094)) - 2047;
                q = int'($urandom_range(4094)) - 2047;
                a = (i < 0) ? -i : i;
                b = (q < 0) ? -q : q;
            end while (i == 0 || q == 0 || a == b);
            push(d, i, q, -1, req);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        checks++;
        if ({ova, ovb, ovc, ovd} !== 4'b0000)
            fail_line("R1", "out_valid after reset", int'({ova, ovb, ovc, ovd}), 0);
        checks++;
        if ({ra, rb, rc, rd} !== 4'b1111)
            fail_line("R1", "in_ready after reset", int'({ra, rb, rc, rd}), 15);
        @(posedge clk); #2;
    endtask

    task automatic t_eight_ties();
        push(0, 5, 5, 0, "R2 R5 tie");
        push(0, -5, 5, 3, "R2 R5 tie");
        push(0, -5, -5, 4, "R2 R5 tie");
        push(0, 5, -5, 7, "R2 R5 tie");
        push(0, 0, 9, 1, "R2 R5 zero");
        push(0, 0, -9, 6, "R2 R5 zero");
        push(0, -9, 0, 3, "R2 R5 zero");
        push(0, 9, 0, 0, "R2 R5 zero");
        push(0, 0, 0, 0, "R2 R5 origin");
        push(0, -2048, -2048, 4, "R2 R5 extreme");
        push(0, -2048, 2047, 3, "R2 R5 extreme");
        push(0, 2047, -2048, 6, "R2 R5 extreme");
        push(0, -2048, 0, 3, "R2 R5 extreme");
        settle();
    endtask

    task automatic t_eight_random();
        push_random(0, 40, "R2 R5 R8");
        settle();
    endtask

    task automatic t_table();
        push(2, 7, 7, 0, "R7 tie");
        push(2, 0, 3, 1, "R7 zero");
        push(2, -7, -7, 4, "R7 tie");
        push_random(2, 30, "R7 R8");
        settle();
    endtask

    task automatic t_quad_bits();
        push(1, 0, 5, 0, "R3 R6 zero");
        push(1, -5, 0, 1, "R3 R6 zero");
        push(1, 0, -5, 3, "R3 R6 zero");
        push(1, 0, 0, 0, "R3 R6 origin");
        push(1, -5, 5, 1, "R3 R6");
        push_random(1, 30, "R3 R6 R11");
        settle();
    endtask

    task automatic t_busy();
        push(1, 100, 200, 0, "R10");
        // push returns just after the accepting edge: ready must be low now
        checks++;
        if (rb !== 1'b0) fail_line("R10", "in_ready after accept", int'(rb), 0);
        vv[1] = 1'b1;
        ii[1] = -12'sd300;
        qq[1] = -12'sd300;
        @(posedge clk); #2;
        vv[1] = 1'b0;
        push(1, -100, 200, 1, "R10");
        settle();
    endtask

    task automatic t_binary();
        push(3, 0, 100, 0, "R4 zero");
        push(3, 0, -100, 0, "R4 zero");
        push(3, -1, 0, 1, "R4");
        push(3, -1, 2000, 1, "R4 q ignored");
        push(3, 1, -2000, 0, "R4 q ignored");
        push_random(3, 20, "R4 R5");
        settle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        for (int d = 0; d < 4; d++) begin
            vv[d] = 1'b0; ii[d] = '0; qq[d] = '0;
        end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        t_eight_ties();
        t_eight_random();
        t_table();
        t_quad_bits();
        t_busy();
        t_binary();
        foreach (sb[k]) begin
            checks++;
            fail_line(sb[k].req, $sformatf("dut%0d missing output", sb[k].d), -1, sb[k].val);
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(64'd20 * 150000);
        if (!done) begin
            checks++;
            fail_line("R8", "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

endmodule